// File: doc/BRIEF.md
# Subroutine Return Stack with Saved Carry

This block is the return-address store of a small 4-bit processor core. When the core enters a subroutine or takes an interrupt, it pushes the return address together with the current carry flag. The block keeps four such entries in last-in first-out order. When the core executes a return, it pops the newest entry and reloads its program counter from the top-of-stack address.

There are two kinds of return. A return from interrupt also reloads the carry flag from the saved copy, and the block signals this on a restore strobe. A return that carries a value leaves the core's carry flag alone. For a call, the block itself adds one to the address of the calling instruction before storing it. An interrupt entry stores the address it is given without change.

The storage is a ring of four slots addressed by a rotating pointer. A fifth outstanding push therefore overwrites the oldest slot, and no error is raised. An occupancy count is brought out so the core can see how many returns are still backed by a real entry. The page bit of the program counter is neither stored nor driven.

Top module: `ret_stack`

## Requirements
- R1: After reset, depth is 0, carryLoad is 0, and every entry reads as address 0 with carry 0. An asynchronous reset at any time brings depth back to 0.
- R2: A push writes {pushCarry, address} into the next slot. From the clock edge that takes the push, topAddr and carryOut show that entry.
- R3: When pushFromCall is 1, the stored address is pushAddr + 1, wrapped to 11 bits (0x7FF becomes 0x000). When pushFromCall is 0, pushAddr is stored as given.
- R4: Pops return entries newest first. After a pop, topAddr and carryOut show the entry that was pushed before the one just removed.
- R5: During a cycle with popRestoreEn = 1, carryLoad is 1 and carryOut equals the carry saved in the entry being popped.
- R6: During a cycle with popKeepEn = 1 and popRestoreEn = 0, carryLoad is 0. The entry is still popped and the pointer still moves.
- R7: A push when depth is already 4 overwrites the oldest entry, depth stays 4, and there is no error output. Popping four times then exposes, in rotation, the newest entry again, and the overwritten oldest value never reappears.
- R8: A pop at depth 0 keeps depth at 0, still rotates the pointer back by one slot, and then shows whatever entry that slot holds.
- R9: A push and a pop in the same cycle act as a pop followed by a push. The top slot is replaced by the new entry, the pointer does not move, and depth is unchanged, except that depth goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pushEn | input | 1 | Save an entry this cycle |
| pushFromCall | input | 1 | 1: store pushAddr+1 (call); 0: store pushAddr (interrupt) |
| pushAddr | input | 11 | Program counter bits [10:0] to save |
| pushCarry | input | 1 | Carry flag to save |
| popRestoreEn | input | 1 | Pop and restore carry (return from interrupt) |
| popKeepEn | input | 1 | Pop without restoring carry (return with value) |
| topAddr | output | 11 | Address held in the newest entry |
| carryOut | output | 1 | Carry held in the newest entry |
| carryLoad | output | 1 | Core must load carryOut into its carry flag this cycle |
| depth | output | 3 | Number of valid entries, 0 to 4 |

## Verification
The bench runs a call/interrupt/return sequence that includes a call from 0x7FF. A design that forgot the wrap, or that added one on interrupt entries, would show the wrong return address. Five nested pushes followed by four pops check that the oldest entry is lost and not the newest. A stack that refused the fifth push would return 4, 3, 2, 1 instead of ending on the rotated newest entry. A pop on an empty stack and a push paired with a pop at depth 0 check that the count saturates and the pointer still rotates. A design that underflowed the count, or moved the pointer on a combined push and pop, would show the wrong depth or the wrong top. Each return kind is checked for the level of carryLoad and for the carry value presented during the pop cycle.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  localparam int RS_DEPTH = 4;
  localparam int RS_PTR_W = $clog2(RS_DEPTH);
  localparam int RS_CNT_W = $clog2(RS_DEPTH + 1);

  typedef struct packed {
    logic                wrEn;
    logic [RS_PTR_W-1:0] wrIdx;
    logic [RS_PTR_W-1:0] rdIdx;
  } rs_strobe_t;
endpackage

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
  import ret_stack_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pushEn,
  input  logic                popRestoreEn,
  input  logic                popKeepEn,
  output rs_strobe_t          strobe,
  output logic                carryLoad,
  output logic [RS_CNT_W-1:0] depth
);
  localparam logic [RS_CNT_W-1:0] FULL = RS_CNT_W'(RS_DEPTH);

  logic [RS_PTR_W-1:0] wrPtr;
  logic [RS_PTR_W-1:0] topIdx;
  logic [RS_CNT_W-1:0] count;
  logic                popAny;

  assign popAny = popRestoreEn | popKeepEn;
  assign topIdx = wrPtr - RS_PTR_W'(1);

  always_comb begin
    strobe.wrEn  = pushEn;
    strobe.wrIdx = popAny ? topIdx : wrPtr;
    strobe.rdIdx = topIdx;
  end

  assign carryLoad = popRestoreEn;
  assign depth     = count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (pushEn && !popAny) begin
        wrPtr <= wrPtr + RS_PTR_W'(1);
        if (count != FULL) count <= count + RS_CNT_W'(1);
      end else if (popAny && !pushEn) begin
        wrPtr <= topIdx;
        if (count != '0) count <= count - RS_CNT_W'(1);
      end else if (popAny && pushEn) begin
        if (count == '0) count <= RS_CNT_W'(1);
      end
    end
  end

  // R7: occupancy never exceeds the number of slots
  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= FULL);

  // R8: an empty pop keeps the count at zero
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (popAny && !pushEn && depth == '0) |=> depth == '0);

  // R9: a combined push and pop leaves the count alone, except from empty
  assert_pushpop_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (popAny && pushEn && depth != '0) |=> $stable(depth));

  assert_pushpop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (popAny && pushEn && depth == '0) |=> depth == RS_CNT_W'(1));
endmodule

// File: rtl/ret_stack_datapath.sv
module ret_stack_datapath
  import ret_stack_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rs_strobe_t        strobe,
  input  logic              pushFromCall,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic              pushCarry,
  output logic [ADDR_W-1:0] topAddr,
  output logic              topCarry
);
  localparam int ENTRY_W = ADDR_W + 1;

  logic [ENTRY_W-1:0] entries [RS_DEPTH];
  logic [ADDR_W-1:0]  storeAddr;
  logic [ENTRY_W-1:0] newEntry;
  logic [ENTRY_W-1:0] topEntry;

  assign storeAddr = pushFromCall ? pushAddr + ADDR_W'(1) : pushAddr;
  assign newEntry  = {pushCarry, storeAddr};

  for (genvar i = 0; i < RS_DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entries[i] <= '0;
      else if (strobe.wrEn && strobe.wrIdx == RS_PTR_W'(i)) entries[i] <= newEntry;
    end
  end

  assign topEntry = entries[strobe.rdIdx];
  assign topAddr  = topEntry[ADDR_W-1:0];
  assign topCarry = topEntry[ADDR_W];

  // R2: the pushed entry becomes the visible top on the next cycle
  assert_push_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrEn |=> (topAddr == $past(storeAddr)) && (topCarry == $past(pushCarry)));
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pushEn,
  input  logic                pushFromCall,
  input  logic [ADDR_W-1:0]   pushAddr,
  input  logic                pushCarry,
  input  logic                popRestoreEn,
  input  logic                popKeepEn,
  output logic [ADDR_W-1:0]   topAddr,
  output logic                carryOut,
  output logic                carryLoad,
  output logic [RS_CNT_W-1:0] depth
);
  rs_strobe_t strobe;

  ret_stack_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pushEn(pushEn),
    .popRestoreEn(popRestoreEn), .popKeepEn(popKeepEn),
    .strobe(strobe), .carryLoad(carryLoad), .depth(depth)
  );

  ret_stack_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .pushFromCall(pushFromCall),
    .pushAddr(pushAddr), .pushCarry(pushCarry),
    .topAddr(topAddr), .topCarry(carryOut)
  );

  // R4: a push directly followed by a pop uncovers the previous top
  assert_lifo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pushEn && !popRestoreEn && !popKeepEn) &&
     (popRestoreEn || popKeepEn) && !pushEn) |=> topAddr == $past(topAddr, 2));

  // R6: a value-return pop never asks the core to reload carry
  assert_keep_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (popKeepEn && !popRestoreEn) |-> !carryLoad);
endmodule

// File: tb/ret_stack_bench.sv
module ret_stack_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        pushEn = 0, pushFromCall = 0, pushCarry = 0;
  logic        popRestoreEn = 0, popKeepEn = 0;
  logic [10:0] pushAddr = '0;
  logic [10:0] topAddr;
  logic        carryOut, carryLoad;
  logic [2:0]  depth;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ret_stack u_ret_stack (
    .clk(clk), .rst_n(rst_n), .pushEn(pushEn), .pushFromCall(pushFromCall),
    .pushAddr(pushAddr), .pushCarry(pushCarry), .popRestoreEn(popRestoreEn),
    .popKeepEn(popKeepEn), .topAddr(topAddr), .carryOut(carryOut),
    .carryLoad(carryLoad), .depth(depth)
  );

  // [30] push [29] call [28] carry [27] popRestore [26] popKeep
  // [25:15] addr [14:4] expected top [3] expected carry [2:0] expected depth
  localparam logic [30:0] VEC [10] = '{
    {1'b1,1'b0,1'b1,1'b0,1'b0,11'h100,11'h100,1'b1,3'd1},
    {1'b1,1'b1,1'b0,1'b0,1'b0,11'h200,11'h201,1'b0,3'd2},
    {1'b1,1'b1,1'b1,1'b0,1'b0,11'h7FF,11'h000,1'b1,3'd3},
    {1'b0,1'b0,1'b0,1'b0,1'b1,11'h000,11'h201,1'b0,3'd2},
    {1'b0,1'b0,1'b0,1'b1,1'b0,11'h000,11'h100,1'b1,3'd1},
    {1'b1,1'b0,1'b0,1'b0,1'b0,11'h055,11'h055,1'b0,3'd2},
    {1'b1,1'b0,1'b1,1'b1,1'b0,11'h0AA,11'h0AA,1'b1,3'd2},
    {1'b0,1'b0,1'b0,1'b0,1'b1,11'h000,11'h100,1'b1,3'd1},
    {1'b0,1'b0,1'b0,1'b1,1'b0,11'h000,11'h000,1'b0,3'd0},
    {1'b0,1'b0,1'b0,1'b0,1'b1,11'h000,11'h000,1'b1,3'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ps, input logic cl, input logic cy,
                       input logic pr, input logic pk, input logic [10:0] ad);
    @(negedge clk);
    pushEn = ps; pushFromCall = cl; pushCarry = cy;
    popRestoreEn = pr; popKeepEn = pk; pushAddr = ad;
    #1;
  endtask

  task automatic finishOp();
    @(posedge clk); #2;
    pushEn = 0; pushFromCall = 0; pushCarry = 0;
    popRestoreEn = 0; popKeepEn = 0; pushAddr = '0;
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    logic prevCarry;
    doReset();
    #1;
    chk("R1 reset depth", depth, 0);
    chk("R1 reset carryLoad", carryLoad, 0);
    chk("R1 reset top addr", topAddr, 0);
    chk("R1 reset carry", carryOut, 0);

    prevCarry = 0;
    for (int i = 0; i < 10; i++) begin
      logic [30:0] v;
      v = VEC[i];
      drive(v[30], v[29], v[28], v[27], v[26], v[25:15]);
      if (v[27]) begin
        chk($sformatf("R5 row %0d carryLoad", i), carryLoad, 1);
        chk($sformatf("R5 row %0d restored carry", i), carryOut, prevCarry);
      end else if (v[26]) begin
        chk($sformatf("R6 row %0d carryLoad", i), carryLoad, 0);
      end
      finishOp();
      chk($sformatf("R2 R3 R4 R8 R9 row %0d top", i), topAddr, v[14:4]);
      chk($sformatf("R2 R4 row %0d carry", i), carryOut, v[3]);
      chk($sformatf("R8 R9 row %0d depth", i), depth, v[2:0]);
      prevCarry = v[3];
    end

    // R1: reset while entries are held
    drive(1, 0, 1, 0, 0, 11'h123); finishOp();
    doReset(); #1;
    chk("R1 mid-run reset depth", depth, 0);
    chk("R1 mid-run reset top", topAddr, 0);

    // R7: five interrupt pushes, oldest lost
    for (int k = 1; k <= 5; k++) begin
      drive(1, 0, k[0], 0, 0, 11'(k)); finishOp();
    end
    chk("R7 depth after overflow", depth, 4);
    chk("R7 top after overflow", topAddr, 5);
    for (int k = 4; k >= 1; k--) begin
      drive(0, 0, 0, 1, 0, '0);
      chk("R5 overflow pop carryLoad", carryLoad, 1);
      chk("R5 overflow pop carry", carryOut, (k == 4) ? 1 : ((k + 1) & 1));
      finishOp();
      chk("R7 overflow pop top", topAddr, (k == 1) ? 5 : k);
    end
    chk("R7 depth after draining", depth, 0);

    // R8: pop on empty rotates pointer, count stays 0
    drive(0, 0, 0, 0, 1, '0);
    chk("R6 empty pop carryLoad", carryLoad, 0);
    finishOp();
    chk("R8 empty pop depth", depth, 0);
    chk("R8 empty pop top", topAddr, 4);

    // R9: push with pop at depth 0
    drive(1, 0, 0, 0, 1, 11'h03C); finishOp();
    chk("R9 push+pop from empty depth", depth, 1);
    chk("R9 push+pop from empty top", topAddr, 11'h03C);
    chk("R9 push+pop from empty carry", carryOut, 0);

    // R3: call increment without wrap
    drive(1, 1, 1, 0, 0, 11'h7FE); finishOp();
    chk("R3 call stores addr+1", topAddr, 11'h7FF);
    chk("R2 call depth", depth, 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1..all actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule